// File: doc/BRIEF.md
# Multicycle Word Stack Machine Core

A small processor core that runs a variable-length instruction set built from 16-bit words. It has eight general registers, a program counter and a dedicated call/return stack. Every word after the opcode is an operand that describes itself. A value below 0x8000 is a literal. A value from 0x8000 to 0x8007 names a register, and anything higher is illegal. The opcode word itself is resolved the same way, so an opcode can come from a register.

The core fetches one word per access over a synchronous, word-addressed memory port. It resolves the operands as they arrive and then executes a single instruction. Arithmetic goes to a separate ALU through a start/done handshake. The remainder operation runs there as a bit-serial divider. Stack traffic goes to a private 256-entry RAM. Character output and character input each use their own valid/ready handshake. The core stops on a halt instruction, an illegal encoding, stack underflow or stack overflow, and it stays stopped until reset.

Top module: `wsm_core`

## Requirements
- R1: After reset all eight registers hold 0, the stack is empty, the halted, illegal and overflow outputs are low, and the first access is a read of word address 0.
- R2: An operand word below 0x8000 is used as a literal. 0x8000–0x8007 reads register R0–R7, taken from bits [2:0]. Any word of 0x8008 or above stops the core with halted and illegal both high.
- R3: The destination operand of set, pop, eq, gt, add, mult, mod, and, or, not, rmem and in must be a register encoding. Any other word stops the core with illegal high.
- R4: Opcodes run from 0 to 21: halt=0, set=1, push=2, pop=3, eq=4, gt=5, jmp=6, jt=7, jf=8, add=9, mult=10, mod=11, and=12, or=13, not=14, rmem=15, wmem=16, call=17, ret=18, out=19, in=20, noop=21. An instruction is one word plus its operands: none for 0, 18 and 21; one for 2, 3, 6, 17, 19 and 20; two for 1, 7, 8, 14, 15 and 16; three for the rest. A resolved opcode above 21 stops the core with illegal high. Opcode 0 stops it with illegal low.
- R5: eq and gt write 1 or 0. add and mult write the result modulo 32768. mod writes the remainder, and 0 when the divisor is 0. and and or are bitwise. not writes the bitwise inverse of the low 15 bits.
- R6: jmp loads the word address in its operand into the program counter. jt branches to its second operand when the first is nonzero, and jf branches when it is zero. When the branch is not taken, execution continues at the next instruction.
- R7: push stores a value on the stack and pop returns the most recently pushed value (LIFO). pop on an empty stack stops the core with illegal high. ret on an empty stack stops the core with illegal low.
- R8: call pushes the word address of the instruction that follows it and then jumps. ret pops a word address and jumps to it.
- R9: The stack holds 256 entries. A push or call that finds the stack full stops the core with overflow high and illegal low.
- R10: rmem reads the memory word at the word address in its second operand into the destination. wmem writes its second operand to the word address given by its first.
- R11: out presents the low byte of its operand and keeps out_valid_o high, with the data stable, until out_ready_i accepts it.
- R12: in holds in_ready_o high until in_valid_i arrives and then loads the byte, zero-extended, into the destination. The byte 0x51 ('Q') instead stops the core with illegal low and leaves the registers unchanged.
- R13: halted_o, illegal_o and overflow_o stay as they are until reset, and a stopped core makes no memory requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | 15 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted |
| out_data_o | output | 8 | Output byte |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Core waiting for an input byte |
| in_data_i | input | 8 | Input byte |
| halted_o | output | 1 | Core has stopped |
| illegal_o | output | 1 | Stopped on an illegal encoding or pop underflow |
| overflow_o | output | 1 | Stopped on a push or call to a full stack |

## Verification
The hardest corner to reach from the ports is the exact full-stack boundary. The stack must take 256 entries without complaint and must fail on entry 257. The stimulus runs a counted loop of 256 pushes through the add, eq and jf instructions, then pops back the last value. A separate endless push loop shows that the next push raises overflow. Operands for the ALU operations come from a fixed-seed random stream, mixed between literal and register forms. The wrap-around, equal-compare and zero-divisor cases are added as directed cases.

// File: rtl/wsm_pkg.sv
package wsm_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned OPC_W   = 5;
  localparam int unsigned NUM_OPC = 22;
  localparam int unsigned RIDX_W  = 3;

  localparam logic [OPC_W-1:0] OPC_HALT = 5'd0,  OPC_SET  = 5'd1,  OPC_PUSH = 5'd2;
  localparam logic [OPC_W-1:0] OPC_POP  = 5'd3,  OPC_EQ   = 5'd4,  OPC_GT   = 5'd5;
  localparam logic [OPC_W-1:0] OPC_JMP  = 5'd6,  OPC_JT   = 5'd7,  OPC_JF   = 5'd8;
  localparam logic [OPC_W-1:0] OPC_ADD  = 5'd9,  OPC_MULT = 5'd10, OPC_MOD  = 5'd11;
  localparam logic [OPC_W-1:0] OPC_AND  = 5'd12, OPC_OR   = 5'd13, OPC_NOT  = 5'd14;
  localparam logic [OPC_W-1:0] OPC_RMEM = 5'd15, OPC_WMEM = 5'd16, OPC_CALL = 5'd17;
  localparam logic [OPC_W-1:0] OPC_RET  = 5'd18, OPC_OUT  = 5'd19, OPC_IN   = 5'd20;
  localparam logic [OPC_W-1:0] OPC_NOOP = 5'd21;

  typedef enum logic [2:0] {
    ALU_EQ, ALU_GT, ALU_ADD, ALU_MUL, ALU_MOD, ALU_AND, ALU_OR, ALU_NOT
  } alu_op_e;

  typedef enum logic [1:0] {K_LIT, K_REG, K_BAD} opnd_kind_e;

  function automatic opnd_kind_e kind_of(logic [WORD_W-1:0] w);
    if (!w[WORD_W-1])                    return K_LIT;
    else if (w[WORD_W-2:RIDX_W] == '0)   return K_REG;
    else                                 return K_BAD;
  endfunction

  function automatic logic [1:0] opnd_count(logic [OPC_W-1:0] op);
    case (op)
      OPC_HALT, OPC_RET, OPC_NOOP:                               return 2'd0;
      OPC_PUSH, OPC_POP, OPC_JMP, OPC_CALL, OPC_OUT, OPC_IN:     return 2'd1;
      OPC_SET, OPC_JT, OPC_JF, OPC_NOT, OPC_RMEM, OPC_WMEM:      return 2'd2;
      default:                                                   return 2'd3;
    endcase
  endfunction

  function automatic logic writes_reg(logic [OPC_W-1:0] op);
    case (op)
      OPC_SET, OPC_POP, OPC_EQ, OPC_GT, OPC_ADD, OPC_MULT, OPC_MOD,
      OPC_AND, OPC_OR, OPC_NOT, OPC_RMEM, OPC_IN:  return 1'b1;
      default:                                     return 1'b0;
    endcase
  endfunction

  function automatic alu_op_e alu_sel(logic [OPC_W-1:0] op);
    case (op)
      OPC_EQ:   return ALU_EQ;
      OPC_GT:   return ALU_GT;
      OPC_ADD:  return ALU_ADD;
      OPC_MULT: return ALU_MUL;
      OPC_MOD:  return ALU_MOD;
      OPC_AND:  return ALU_AND;
      OPC_OR:   return ALU_OR;
      default:  return ALU_NOT;
    endcase
  endfunction
endpackage

// File: rtl/wsm_alu.sv
module wsm_alu
  import wsm_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic [W-1:0] res_o
);
  localparam int unsigned CNT_W = $clog2(W) + 1;
  localparam logic [W-1:0] MASK = {1'b0, {(W-1){1'b1}}};

  logic           busy_q, done_q;
  alu_op_e        op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]   dvd_q, div_q, res_q, quick;
  logic [W:0]     rem_q, rem_sh, rem_nx;

  always_comb begin
    case (op_i)
      ALU_EQ:  quick = W'(a_i == b_i);
      ALU_GT:  quick = W'(a_i > b_i);
      ALU_ADD: quick = (a_i + b_i) & MASK;
      ALU_MUL: quick = (a_i * b_i) & MASK;
      ALU_AND: quick = a_i & b_i;
      ALU_OR:  quick = a_i | b_i;
      ALU_NOT: quick = ~a_i & MASK;
      default: quick = '0;  // mod by zero
    endcase
  end

  // restoring divider step, one quotient bit per cycle
  always_comb begin
    rem_sh = {rem_q[W-1:0], dvd_q[W-1]};
    rem_nx = (rem_sh >= {1'b0, div_q}) ? rem_sh - {1'b0, div_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; done_q <= 1'b0; op_q <= ALU_EQ; cnt_q <= '0;
      dvd_q <= '0; div_q <= '0; rem_q <= '0; res_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        op_q <= op_i;
        if (op_i == ALU_MOD && b_i != '0) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(W);
          dvd_q  <= a_i;
          div_q  <= b_i;
          rem_q  <= '0;
        end else begin
          res_q  <= quick;
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        rem_q <= rem_nx;
        dvd_q <= {dvd_q[W-2:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= rem_nx[W-1:0];
        end
      end
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;

  AST_ALU_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && (op_q == ALU_ADD || op_q == ALU_MUL || op_q == ALU_NOT) |-> !res_q[W-1]); // R5
  AST_ALU_BOOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && (op_q == ALU_EQ || op_q == ALU_GT) |-> res_q[W-1:1] == '0); // R5
  AST_ALU_NO_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_i); // R5
endmodule

// File: rtl/wsm_regfile.sv
module wsm_regfile
  import wsm_pkg::*;
#(
  parameter int unsigned NREG = 8,
  parameter int unsigned W    = WORD_W,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))     regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[ridx_i];
endmodule

// File: rtl/wsm_stack_ram.sv
module wsm_stack_ram
  import wsm_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned W     = WORD_W,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rd_q <= mem_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/wsm_core.sv
module wsm_core
  import wsm_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [7:0]        in_data_i,
  output logic              halted_o,
  output logic              illegal_o,
  output logic              overflow_o
);
  localparam int unsigned STK_AW = $clog2(STACK_DEPTH);
  localparam int unsigned SP_W   = STK_AW + 1;
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(STACK_DEPTH);
  localparam logic [7:0] QUIT_CHAR = 8'h51;

  typedef enum logic [3:0] {
    S_FETCH, S_OPC, S_OREQ, S_OPND, S_EXEC, S_ALU, S_LOAD,
    S_POPW, S_RETW, S_OUT, S_IN, S_HALT
  } state_e;

  state_e state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_seq;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic [OPC_W-1:0]  opc_q, opc_d;
  logic [1:0]        nops_q, nops_d, idx_q, idx_d;
  logic [WORD_W-1:0] opv_q [3];
  logic [WORD_W-1:0] opv_d [3];
  logic [RIDX_W-1:0] dst_q, dst_d;
  logic              ill_q, ill_d, ovf_q, ovf_d;

  opnd_kind_e        kind;
  logic [WORD_W-1:0] rf_rdata, resolved, rf_wdata, stk_wdata, stk_rdata, alu_res;
  logic              rf_we, stk_we, stk_re, alu_start, alu_done, bad_opnd, dst_pos;

  wsm_regfile #(.NREG(8), .W(WORD_W)) u_rf (
    .clk_i, .rst_ni, .we_i(rf_we), .widx_i(dst_q), .wdata_i(rf_wdata),
    .ridx_i(mem_rdata_i[RIDX_W-1:0]), .rdata_o(rf_rdata)
  );

  wsm_stack_ram #(.DEPTH(STACK_DEPTH), .W(WORD_W)) u_stk (
    .clk_i, .we_i(stk_we), .waddr_i(sp_q[STK_AW-1:0]), .wdata_i(stk_wdata),
    .re_i(stk_re), .raddr_i(STK_AW'(sp_q - 1'b1)), .rdata_o(stk_rdata)
  );

  wsm_alu #(.W(WORD_W)) u_alu (
    .clk_i, .rst_ni, .start_i(alu_start), .op_i(alu_sel(opc_q)),
    .a_i(opv_q[1]), .b_i(opv_q[2]), .done_o(alu_done), .res_o(alu_res)
  );

  assign kind     = kind_of(mem_rdata_i);
  assign resolved = (kind == K_REG) ? rf_rdata : mem_rdata_i;
  assign pc_seq   = pc_q + ADDR_W'(nops_q) + ADDR_W'(1);
  assign dst_pos  = (idx_q == 2'd0) && writes_reg(opc_q);
  assign bad_opnd = dst_pos ? (kind != K_REG) : (kind == K_BAD);

  always_comb begin
    state_d = state_q; pc_d = pc_q; sp_d = sp_q; opc_d = opc_q;
    nops_d = nops_q; idx_d = idx_q; opv_d = opv_q; dst_d = dst_q;
    ill_d = ill_q; ovf_d = ovf_q;
    mem_req_o = 1'b0; mem_we_o = 1'b0; mem_addr_o = pc_q; mem_wdata_o = '0;
    rf_we = 1'b0; rf_wdata = '0; stk_we = 1'b0; stk_wdata = '0; stk_re = 1'b0;
    alu_start = 1'b0; out_valid_o = 1'b0; in_ready_o = 1'b0;
    case (state_q)
      S_FETCH: begin
        mem_req_o = 1'b1;
        state_d   = S_OPC;
      end
      S_OPC: begin
        if (kind == K_BAD || resolved > WORD_W'(NUM_OPC - 1)) begin
          ill_d = 1'b1; state_d = S_HALT;
        end else begin
          opc_d  = resolved[OPC_W-1:0];
          nops_d = opnd_count(resolved[OPC_W-1:0]);
          idx_d  = 2'd0;
          case (resolved[OPC_W-1:0])
            OPC_HALT: state_d = S_HALT;
            OPC_NOOP: begin pc_d = pc_q + ADDR_W'(1); state_d = S_FETCH; end
            OPC_RET: begin
              if (sp_q == '0) state_d = S_HALT;
              else begin stk_re = 1'b1; sp_d = sp_q - 1'b1; state_d = S_RETW; end
            end
            default: state_d = S_OREQ;
          endcase
        end
      end
      S_OREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = pc_q + ADDR_W'(idx_q) + ADDR_W'(1);
        state_d    = S_OPND;
      end
      S_OPND: begin
        if (bad_opnd) begin
          ill_d = 1'b1; state_d = S_HALT;
        end else begin
          if (dst_pos) dst_d = mem_rdata_i[RIDX_W-1:0];
          else         opv_d[idx_q] = resolved;
          idx_d   = idx_q + 2'd1;
          state_d = (idx_q == nops_q - 2'd1) ? S_EXEC : S_OREQ;
        end
      end
      S_EXEC: begin
        case (opc_q)
          OPC_SET: begin
            rf_we = 1'b1; rf_wdata = opv_q[1]; pc_d = pc_seq; state_d = S_FETCH;
          end
          OPC_PUSH, OPC_CALL: begin
            if (sp_q == SP_FULL) begin
              ovf_d = 1'b1; state_d = S_HALT;
            end else begin
              stk_we    = 1'b1;
              stk_wdata = (opc_q == OPC_CALL) ? WORD_W'(pc_seq) : opv_q[0];
              sp_d      = sp_q + 1'b1;
              pc_d      = (opc_q == OPC_CALL) ? opv_q[0][ADDR_W-1:0] : pc_seq;
              state_d   = S_FETCH;
            end
          end
          OPC_POP: begin
            if (sp_q == '0) begin
              ill_d = 1'b1; state_d = S_HALT;
            end else begin
              stk_re = 1'b1; sp_d = sp_q - 1'b1; state_d = S_POPW;
            end
          end
          OPC_JMP: begin pc_d = opv_q[0][ADDR_W-1:0]; state_d = S_FETCH; end
          OPC_JT, OPC_JF: begin
            pc_d    = ((opv_q[0] != '0) == (opc_q == OPC_JT)) ? opv_q[1][ADDR_W-1:0] : pc_seq;
            state_d = S_FETCH;
          end
          OPC_RMEM: begin
            mem_req_o = 1'b1; mem_addr_o = opv_q[1][ADDR_W-1:0]; state_d = S_LOAD;
          end
          OPC_WMEM: begin
            mem_req_o = 1'b1; mem_we_o = 1'b1;
            mem_addr_o = opv_q[0][ADDR_W-1:0]; mem_wdata_o = opv_q[1];
            pc_d = pc_seq; state_d = S_FETCH;
          end
          OPC_OUT: state_d = S_OUT;
          OPC_IN:  state_d = S_IN;
          default: begin alu_start = 1'b1; state_d = S_ALU; end
        endcase
      end
      S_ALU: if (alu_done) begin
        rf_we = 1'b1; rf_wdata = alu_res; pc_d = pc_seq; state_d = S_FETCH;
      end
      S_LOAD: begin
        rf_we = 1'b1; rf_wdata = mem_rdata_i; pc_d = pc_seq; state_d = S_FETCH;
      end
      S_POPW: begin
        rf_we = 1'b1; rf_wdata = stk_rdata; pc_d = pc_seq; state_d = S_FETCH;
      end
      S_RETW: begin pc_d = stk_rdata[ADDR_W-1:0]; state_d = S_FETCH; end
      S_OUT: begin
        out_valid_o = 1'b1;
        if (out_ready_i) begin pc_d = pc_seq; state_d = S_FETCH; end
      end
      S_IN: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          if (in_data_i == QUIT_CHAR) state_d = S_HALT;
          else begin
            rf_we = 1'b1; rf_wdata = WORD_W'(in_data_i); pc_d = pc_seq; state_d = S_FETCH;
          end
        end
      end
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH; pc_q <= '0; sp_q <= '0; opc_q <= '0; nops_q <= '0;
      idx_q <= '0; dst_q <= '0; ill_q <= 1'b0; ovf_q <= 1'b0;
      for (int i = 0; i < 3; i++) opv_q[i] <= '0;
    end else begin
      state_q <= state_d; pc_q <= pc_d; sp_q <= sp_d; opc_q <= opc_d;
      nops_q <= nops_d; idx_q <= idx_d; dst_q <= dst_d; ill_q <= ill_d; ovf_q <= ovf_d;
      for (int i = 0; i < 3; i++) opv_q[i] <= opv_d[i];
    end
  end

  assign out_data_o = opv_q[0][7:0];
  assign halted_o   = (state_q == S_HALT);
  assign illegal_o  = ill_q;
  assign overflow_o = ovf_q;

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(illegal_o) && $stable(overflow_o)); // R13
  AST_HALT_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o); // R13
  AST_ILLEGAL_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o || overflow_o) |-> halted_o); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_we |-> sp_q < SP_FULL); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_re |-> sp_q != '0); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R11
  AST_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> in_ready_o); // R12
endmodule

// File: tb/wsm_core_tb_top.sv
module wsm_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 4096;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mem_req_o, mem_we_o;
  logic [14:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;
  logic out_valid_o, out_ready_i, in_valid_i, in_ready_o;
  logic [7:0] out_data_o, in_data_i;
  logic halted_o, illegal_o, overflow_o;

  logic [15:0] mem [MEM_WORDS];
  logic [7:0]  out_buf [64];
  logic [7:0]  in_buf [16];
  int out_cnt, in_cnt, in_idx, wp, checks, errors, cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsm_core dut_i (.clk_i(clk), .*);

  always @(posedge clk) if (mem_req_o) begin
    if (mem_we_o) mem[mem_addr_o[11:0]] <= mem_wdata_o;
    else          mem_rdata_i <= mem[mem_addr_o[11:0]];
  end

  always @(posedge clk) begin
    if (!rst_ni) out_cnt <= 0;
    else if (out_valid_o && out_ready_i) begin
      out_buf[out_cnt[5:0]] <= out_data_o;
      out_cnt <= out_cnt + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst_ni) in_idx <= 0;
    else if (in_valid_i && in_ready_o) in_idx <= in_idx + 1;
  end
  assign in_valid_i = in_idx < in_cnt;
  assign in_data_i  = in_buf[in_idx[3:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish (cycles %0d, limit %0d)", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic emit(input int w);
    mem[wp[11:0]] = 16'(w);
    wp++;
  endtask

  task automatic begin_prog();
    rst_ni = 1'b0; out_ready_i = 1'b1; in_cnt = 0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    wp = 0;
  endtask

  task automatic release_rst();
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic wait_halt(input int limit);
    for (int n = 0; n < limit && !halted_o; n++) @(negedge clk);
  endtask

  task automatic run_prog(input int limit);
    release_rst();
    wait_halt(limit);
  endtask

  task automatic chk_stop(input string req, input bit ill, input bit ovf);
    check(halted_o === 1'b1, {req, " halted"}, halted_o, 1);
    check(illegal_o === ill, {req, " illegal"}, illegal_o, ill);
    check(overflow_o === ovf, {req, " overflow"}, overflow_o, ovf);
  endtask

  task automatic chk_out(input string req, input string s);
    check(out_cnt == s.len(), {req, " out count"}, out_cnt, s.len());
    for (int i = 0; i < s.len() && i < out_cnt; i++)
      check(out_buf[i] == s[i], {req, " out byte"}, out_buf[i], s[i]);
  endtask

  function automatic int f_alu(input int op, input int a, input int b);
    case (op)
      4:  return (a == b) ? 1 : 0;
      5:  return (a > b) ? 1 : 0;
      9:  return (a + b) % 32768;
      10: return (a * b) % 32768;
      11: return (b == 0) ? 0 : a % b;
      12: return a & b;
      13: return a | b;
      default: return (~a) & 32'h7fff;
    endcase
  endfunction

  task automatic alu_case(input int op, input int a, input int b, input bit lit);
    begin_prog();
    emit(1); emit(16'h8001); emit(a);
    emit(1); emit(16'h8002); emit(b);
    emit(op); emit(16'h8003); emit(16'h8001);
    if (op != 14) emit(lit ? b : 16'h8002);
    emit(16); emit(16'h800); emit(16'h8003);
    emit(0);
    run_prog(400);
    check(mem[16'h800] == 16'(f_alu(op, a, b)), $sformatf("R5 op %0d R2 lit %0d", op, lit),
          mem[16'h800], f_alu(op, a, b));
    check(illegal_o == 1'b0, "R5 no illegal", illegal_o, 0);
  endtask

  initial begin
    automatic int ops[8] = '{4, 5, 9, 10, 11, 12, 13, 14};
    checks = 0; errors = 0; cyc = 0; out_ready_i = 1'b1; in_cnt = 0;
    void'($urandom(32'd4242));

    // R1 reset state, registers zero
    begin_prog();
    emit(19); emit(16'h8000); emit(19); emit(16'h8007); emit(0);
    release_rst(); #1;
    check(mem_req_o && mem_addr_o == 0 && !mem_we_o, "R1 first fetch at 0", mem_addr_o, 0);
    check(!halted_o && !illegal_o && !overflow_o, "R1 status low", {halted_o, illegal_o, overflow_o}, 0);
    wait_halt(200);
    check(out_cnt == 2 && out_buf[0] == 0 && out_buf[1] == 0, "R1 regs zero", out_buf[0], 0);
    chk_stop("R4 halt opcode", 0, 0);

    // R5 directed corners
    alu_case(9, 16'h7fff, 1, 1);
    alu_case(10, 16'h7fff, 16'h7fff, 0);
    alu_case(11, 1234, 0, 1);
    alu_case(5, 77, 77, 0);
    alu_case(4, 77, 77, 1);
    alu_case(14, 0, 0, 0);
    // R5 random
    for (int i = 0; i < 24; i++) begin
      automatic int op = ops[$urandom % 8];
      automatic int a = $urandom & 32'h7fff;
      automatic int b = (i % 3 == 0) ? ($urandom % 50) + 1 : $urandom & 32'h7fff;
      alu_case(op, a, b, 1'($urandom % 2));
    end

    // R2 illegal operand value and illegal opcode word
    begin_prog();
    emit(1); emit(16'h8000); emit(16'h8008); emit(0);
    run_prog(100);
    chk_stop("R2 operand 0x8008", 1, 0);
    begin_prog();
    emit(16'h9000);
    run_prog(100);
    chk_stop("R2 opcode word 0x9000", 1, 0);

    // R13 sticky and silent after stop
    repeat (20) @(negedge clk);
    check(halted_o && illegal_o && !mem_req_o, "R13 sticky, no requests", {halted_o, illegal_o, mem_req_o}, 3'b110);

    // R3 destination must be register
    begin_prog();
    emit(1); emit(5); emit(7); emit(0);
    run_prog(100);
    chk_stop("R3 literal dest", 1, 0);
    begin_prog();
    emit(9); emit(16'h8008); emit(1); emit(1); emit(0);
    run_prog(100);
    chk_stop("R3 out-of-range dest", 1, 0);

    // R4 unknown opcode, opcode via register
    begin_prog();
    emit(22);
    run_prog(100);
    chk_stop("R4 opcode 22", 1, 0);
    begin_prog();
    emit(1); emit(16'h8000); emit(21); emit(16'h8000); emit(19); emit(16'h4b); emit(0);
    run_prog(200);
    chk_out("R4 noop via register", "K");
    chk_stop("R4", 0, 0);

    // R6 jumps
    begin_prog();
    emit(7); emit(1); emit(16'h10); emit(19); emit(16'h58); emit(0);
    wp = 16'h10; emit(8); emit(0); emit(16'h20); emit(19); emit(16'h59); emit(0);
    wp = 16'h20; emit(7); emit(0); emit(16'h30); emit(19); emit(16'h41);
    emit(8); emit(5); emit(16'h30); emit(19); emit(16'h42);
    emit(6); emit(16'h40); emit(19); emit(16'h5a); emit(0);
    wp = 16'h30; emit(19); emit(16'h57); emit(0);
    wp = 16'h40; emit(19); emit(16'h45); emit(0);
    run_prog(400);
    chk_out("R6 branch pattern", "ABE");

    // R7 R8 LIFO and call/return
    begin_prog();
    emit(2); emit(10); emit(2); emit(20); emit(3); emit(16'h8000); emit(3); emit(16'h8001);
    emit(19); emit(16'h8000); emit(19); emit(16'h8001);
    emit(17); emit(16'h100); emit(19); emit(16'h43); emit(0);
    wp = 16'h100; emit(19); emit(16'h53); emit(18);
    run_prog(600);
    check(out_cnt == 4 && out_buf[0] == 20 && out_buf[1] == 10, "R7 LIFO order", out_buf[0], 20);
    check(out_buf[2] == 8'h53 && out_buf[3] == 8'h43, "R8 call/ret", out_buf[3], 8'h43);
    chk_stop("R8", 0, 0);
    begin_prog();
    emit(17); emit(16'h100); emit(0);
    wp = 16'h100; emit(3); emit(16'h8002); emit(19); emit(16'h8002); emit(0);
    run_prog(200);
    check(out_cnt == 1 && out_buf[0] == 2, "R8 pushed return address", out_buf[0], 2);
    begin_prog();
    emit(3); emit(16'h8000);
    run_prog(100);
    chk_stop("R7 pop empty", 1, 0);
    begin_prog();
    emit(18);
    run_prog(100);
    chk_stop("R7 ret empty", 0, 0);

    // R9 exactly 256 entries fit
    begin_prog();
    emit(1); emit(16'h8000); emit(0);
    emit(2); emit(16'h8000);
    emit(9); emit(16'h8000); emit(16'h8000); emit(1);
    emit(4); emit(16'h8001); emit(16'h8000); emit(256);
    emit(8); emit(16'h8001); emit(3);
    emit(3); emit(16'h8002); emit(19); emit(16'h8002); emit(0);
    run_prog(20000);
    check(out_cnt == 1 && out_buf[0] == 255, "R9 256 pushes fit", out_buf[0], 255);
    chk_stop("R9 full no overflow", 0, 0);
    // R9 the 257th push overflows
    begin_prog();
    emit(2); emit(1); emit(6); emit(0);
    run_prog(20000);
    chk_stop("R9 overflow", 0, 1);

    // R10 memory read and write
    begin_prog();
    emit(15); emit(16'h8000); emit(16'h300);
    emit(1); emit(16'h8005); emit(16'h302);
    emit(16); emit(16'h301); emit(16'h8000);
    emit(16); emit(16'h8005); emit(77); emit(0);
    mem[16'h300] = 16'hbeef;
    run_prog(300);
    check(mem[16'h301] == 16'hbeef, "R10 rmem/wmem", mem[16'h301], 16'hbeef);
    check(mem[16'h302] == 77, "R10 wmem register address", mem[16'h302], 77);

    // R11 output stall
    begin_prog();
    emit(19); emit(16'h48); emit(19); emit(16'h49); emit(0);
    out_ready_i = 1'b0;
    release_rst();
    repeat (15) @(negedge clk);
    check(out_valid_o && out_data_o == 8'h48 && out_cnt == 0, "R11 held while not ready", out_data_o, 8'h48);
    out_ready_i = 1'b1;
    wait_halt(200);
    chk_out("R11 bytes after release", "HI");

    // R12 input wait and quit character
    begin_prog();
    emit(20); emit(16'h8000); emit(19); emit(16'h8000);
    emit(20); emit(16'h8001); emit(19); emit(16'h4e); emit(0);
    in_buf[0] = 8'h68; in_buf[1] = 8'h51;
    release_rst();
    repeat (12) @(negedge clk);
    check(in_ready_o && !halted_o, "R12 waits for input", in_ready_o, 1);
    in_cnt = 2;
    wait_halt(200);
    chk_out("R12 input echo, quit", "h");
    chk_stop("R12 quit", 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule